// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block produces the raster timing for a TFT panel from a small set of configuration words. It emits a pixel-clock enable strobe derived from the system clock, horizontal and vertical sync, a data-enable and the current active-area coordinates. A downstream fetch unit uses the coordinates and the strobe to supply pixel data, which this block does not handle.

Software writes the timing words through a single-cycle write port into staging registers. The generator reads from a separate live copy. That copy follows the staging registers while the generator is idle and reloads only at the last pixel strobe of a frame while it is running, so a mid-frame write never tears a frame. Setting the run bit starts a frame at the first pixel of the first vertical sync line. Clearing it lets the current frame finish before all outputs fall to their inactive levels.

Top module: `tft_tgen`

## Requirements
- R1: Register 1 (vertical word) holds, each as value minus one, the vertical back porch in bits [31:24], active lines in [23:14], vertical front porch in [13:6] and vertical sync width in [5:0], all counted in lines.
- R2: Register 2 (horizontal word) holds, each as value minus one, the horizontal back porch in [25:19], active pixels in [18:8] and horizontal front porch in [7:0]. Register 3 holds the horizontal sync width minus one in [7:0]. All are counted in pixel strobes.
- R3: Register 0 (control) holds the run bit in bit 0 and a divider D in [17:8]. While running, `pix_ce` is high for exactly one system cycle in every 2*(D+1) cycles.
- R4: Each line runs, in pixel strobes: sync, then back porch, then active, then front porch. A line totals the sum of the four intervals, and `hsync_o` is active during the sync interval.
- R5: Each frame runs, in lines: sync, then back porch, then active, then front porch. A frame totals the sum of the four intervals, and `vsync_o` is active during the vertical sync lines.
- R6: `de_o` is active only when both the horizontal and the vertical position lie in their active intervals.
- R7: When the run bit is set while idle, the generator starts two cycles after the write cycle at the first pixel of the first vertical sync line, with hsync and vsync both active.
- R8: When the run bit is cleared, the current frame completes. After that, `pix_ce` stays low and all outputs stay at their inactive levels.
- R9: While running, writes to any register take effect only at the frame boundary. While idle, they take effect on the cycle after the write.
- R10: Register 4 holds the polarity bits: bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts DE. With all three bits zero, the syncs are active low and DE is active high.
- R11: `pix_x` and `pix_y` give the zero-based position inside the horizontal and the vertical active interval respectively, and read zero outside it or while idle.
- R12: After reset, all registers are zero, the generator is idle, `pix_ce` is low, hsync and vsync are high and DE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register index (0 control, 1 vertical, 2 horizontal, 3 hsync width, 4 polarity) |
| cfg_wdata | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel clock enable strobe |
| hsync_o | output | 1 | Horizontal sync to panel |
| vsync_o | output | 1 | Vertical sync to panel |
| de_o | output | 1 | Data enable to panel |
| pix_x | output | 11 | Column inside the active line |
| pix_y | output | 10 | Row inside the active frame |

## Verification
The delicate cycle is the last pixel strobe of a frame. In that cycle three things happen together: both counters wrap, the live configuration reloads from staging, and the run bit is sampled to decide whether to stop. The bench provokes this by writing a new divider, new polarity and a cleared run bit in mid-frame. A cycle-accurate behavioural model predicts every output on every clock. The frame after each such write must show the old timing up to the boundary and the new timing after it, and the generator must stop exactly at that boundary.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
   // field widths of the configuration words
   localparam int VSW_W = 6;
   localparam int VFP_W = 8;
   localparam int VLN_W = 10;
   localparam int VBP_W = 8;
   localparam int HFP_W = 8;
   localparam int HPX_W = 11;
   localparam int HBP_W = 7;
   localparam int HSW_W = 8;
   localparam int DIV_W = 10;
   localparam int POL_W = 3;
   // bit positions inside the words
   localparam int VSW_LSB = 0;
   localparam int VFP_LSB = 6;
   localparam int VLN_LSB = 14;
   localparam int VBP_LSB = 24;
   localparam int HFP_LSB = 0;
   localparam int HPX_LSB = 8;
   localparam int HBP_LSB = 19;
   localparam int HSW_LSB = 0;
   localparam int DIV_LSB = 8;
   localparam int RUN_BIT = 0;
   // counter widths large enough for the longest line / frame
   localparam int H_CNT_W = $clog2((1 << HSW_W) + (1 << HBP_W) + (1 << HPX_W) + (1 << HFP_W));
   localparam int V_CNT_W = $clog2((1 << VSW_W) + (1 << VBP_W) + (1 << VLN_W) + (1 << VFP_W));

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_VERT = 3'd1,
      REG_HORZ = 3'd2,
      REG_HSW  = 3'd3,
      REG_POL  = 3'd4
   } tgen_reg_e;

   typedef struct packed {
      logic [POL_W-1:0] pol;
      logic [DIV_W-1:0] div;
      logic [HSW_W-1:0] hsw;
      logic [HBP_W-1:0] hbp;
      logic [HPX_W-1:0] hpx;
      logic [HFP_W-1:0] hfp;
      logic [VBP_W-1:0] vbp;
      logic [VLN_W-1:0] vln;
      logic [VFP_W-1:0] vfp;
      logic [VSW_W-1:0] vsw;
   } tgen_cfg_t;
endpackage

// File: rtl/tgen_regs.sv
module tgen_regs
   import tgen_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              load,
   output logic              stage_run,
   output tgen_cfg_t         live
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_VERT = ADDR_W'(REG_VERT);
   localparam logic [ADDR_W-1:0] A_HORZ = ADDR_W'(REG_HORZ);
   localparam logic [ADDR_W-1:0] A_HSW  = ADDR_W'(REG_HSW);
   localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(REG_POL);

   tgen_cfg_t stage;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage     <= '0;
         stage_run <= 1'b0;
         live      <= '0;
      end else begin
         if (load) live <= stage;
         if (we) begin
            case (addr)
               A_CTRL: begin
                  stage_run <= wdata[RUN_BIT];
                  stage.div <= wdata[DIV_LSB +: DIV_W];
               end
               A_VERT: begin
                  stage.vbp <= wdata[VBP_LSB +: VBP_W];
                  stage.vln <= wdata[VLN_LSB +: VLN_W];
                  stage.vfp <= wdata[VFP_LSB +: VFP_W];
                  stage.vsw <= wdata[VSW_LSB +: VSW_W];
               end
               A_HORZ: begin
                  stage.hbp <= wdata[HBP_LSB +: HBP_W];
                  stage.hpx <= wdata[HPX_LSB +: HPX_W];
                  stage.hfp <= wdata[HFP_LSB +: HFP_W];
               end
               A_HSW: stage.hsw <= wdata[HSW_LSB +: HSW_W];
               A_POL: stage.pol <= wdata[POL_W-1:0];
               default: ;
            endcase
         end
      end
   end

   AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(live)); // R9
endmodule

// File: rtl/tgen_clkdiv.sv
module tgen_clkdiv #(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             ce
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   // period 2*(div+1) cycles -> terminal count 2*div+1
   assign last = {div, 1'b1};
   assign ce   = run && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (cnt >= last) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end

   AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> !ce); // R3
endmodule

// File: rtl/tgen_axis.sv
module tgen_axis #(
   parameter int CNT_W = 12,
   parameter int SW_W  = 8,
   parameter int BP_W  = 7,
   parameter int ACT_W = 11,
   parameter int FP_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic             step,
   input  logic [SW_W-1:0]  sw_m1,
   input  logic [BP_W-1:0]  bp_m1,
   input  logic [ACT_W-1:0] act_m1,
   input  logic [FP_W-1:0]  fp_m1,
   output logic             at_end,
   output logic             in_sync,
   output logic             in_act,
   output logic [ACT_W-1:0] act_pos
);
   localparam int NEED_W = $clog2((1 << SW_W) + (1 << BP_W) + (1 << ACT_W) + (1 << FP_W));

   generate
      if (CNT_W < NEED_W) begin : g_bad_width
         $error("tgen_axis: CNT_W too small for the field widths");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_first;
   logic [CNT_W-1:0] act_stop;
   logic [CNT_W-1:0] last;

   // interval order: sync, back porch, active, front porch
   assign act_first = CNT_W'(sw_m1) + CNT_W'(bp_m1) + CNT_W'(2);
   assign act_stop  = act_first + CNT_W'(act_m1) + CNT_W'(1);
   assign last      = act_stop + CNT_W'(fp_m1);

   assign at_end  = (cnt == last);
   assign in_sync = (cnt <= CNT_W'(sw_m1));
   assign in_act  = (cnt >= act_first) && (cnt < act_stop);
   assign act_pos = ACT_W'(cnt - act_first);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else if (step) cnt <= at_end ? '0 : cnt + 1'b1;
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt <= last); // R4, R5
endmodule

// File: rtl/tft_tgen.sv
module tft_tgen
   import tgen_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int OUT_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic              pix_ce,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic [HPX_W-1:0]  pix_x,
   output logic [VLN_W-1:0]  pix_y
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("tft_tgen: ADDR_W must be at least 3");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
         $error("tft_tgen: OUT_REG must be 0 or 1");
      end
   endgenerate

   tgen_cfg_t        live;
   logic             stage_run;
   logic             running;
   logic             start;
   logic             ce;
   logic             h_end, h_sync, h_act;
   logic             v_end, v_sync, v_act;
   logic [HPX_W-1:0] h_pos;
   logic [VLN_W-1:0] v_pos;
   logic             frame_end;
   logic             hs_a, vs_a, de_a;
   logic             hs_n, vs_n, de_n;
   logic [HPX_W-1:0] px_n;
   logic [VLN_W-1:0] py_n;

   assign start     = !running && stage_run;
   assign frame_end = ce && h_end && v_end;

   tgen_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .load      (!running || frame_end),
      .stage_run (stage_run),
      .live      (live)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) running <= 1'b0;
      else if (start) running <= 1'b1;
      else if (frame_end && !stage_run) running <= 1'b0;
   end

   tgen_clkdiv #(.DIV_W(DIV_W)) div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .div   (live.div),
      .ce    (ce)
   );

   tgen_axis #(
      .CNT_W(H_CNT_W), .SW_W(HSW_W), .BP_W(HBP_W), .ACT_W(HPX_W), .FP_W(HFP_W)
   ) h_axis_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (running),
      .clr     (start),
      .step    (ce),
      .sw_m1   (live.hsw),
      .bp_m1   (live.hbp),
      .act_m1  (live.hpx),
      .fp_m1   (live.hfp),
      .at_end  (h_end),
      .in_sync (h_sync),
      .in_act  (h_act),
      .act_pos (h_pos)
   );

   tgen_axis #(
      .CNT_W(V_CNT_W), .SW_W(VSW_W), .BP_W(VBP_W), .ACT_W(VLN_W), .FP_W(VFP_W)
   ) v_axis_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (running),
      .clr     (start),
      .step    (ce && h_end),
      .sw_m1   (live.vsw),
      .bp_m1   (live.vbp),
      .act_m1  (live.vln),
      .fp_m1   (live.vfp),
      .at_end  (v_end),
      .in_sync (v_sync),
      .in_act  (v_act),
      .act_pos (v_pos)
   );

   // active-high internal strobes, then polarity
   assign hs_a = running && h_sync;
   assign vs_a = running && v_sync;
   assign de_a = running && h_act && v_act;
   assign hs_n = hs_a ^ ~live.pol[0];
   assign vs_n = vs_a ^ ~live.pol[1];
   assign de_n = de_a ^ live.pol[2];
   assign px_n = (running && h_act) ? h_pos : '0;
   assign py_n = (running && v_act) ? v_pos : '0;

   generate
      if (OUT_REG == 1) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pix_ce  <= 1'b0;
               hsync_o <= 1'b1;
               vsync_o <= 1'b1;
               de_o    <= 1'b0;
               pix_x   <= '0;
               pix_y   <= '0;
            end else begin
               pix_ce  <= ce;
               hsync_o <= hs_n;
               vsync_o <= vs_n;
               de_o    <= de_n;
               pix_x   <= px_n;
               pix_y   <= py_n;
            end
         end
      end else begin : g_out_comb
         assign pix_ce  = ce;
         assign hsync_o = hs_n;
         assign vsync_o = vs_n;
         assign de_o    = de_n;
         assign pix_x   = px_n;
         assign pix_y   = py_n;
      end
   endgenerate

   AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      de_a |-> !hs_a && !vs_a); // R6
   AST_START_IN_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> vs_a && hs_a); // R7
   AST_STOP_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(frame_end)); // R8
   AST_IDLE_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !ce); // R8
endmodule

// File: tb/tft_tgen_tb.sv
module tft_tgen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        pix_ce, hsync_o, vsync_o, de_o;
   logic [10:0] pix_x;
   logic [9:0]  pix_y;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tft_tgen dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .pix_ce(pix_ce), .hsync_o(hsync_o),
      .vsync_o(vsync_o), .de_o(de_o), .pix_x(pix_x), .pix_y(pix_y)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // index: 0 hsync,1 hbp,2 hact,3 hfp,4 vsync,5 vbp,6 vact,7 vfp,8 div,9 pol
   int st[10];
   int lv[10];
   int st_run, m_run, m_div, m_h, m_v;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (st[i]) begin st[i] = 0; lv[i] = 0; end
         st_run = 0; m_run = 0; m_div = 0; m_h = 0; m_v = 0;
      end else begin
         if (m_run == 0) begin
            lv = st;
            if (st_run != 0) begin m_run = 1; m_div = 0; m_h = 0; m_v = 0; end
         end else begin
            int htot, vtot;
            bit ce;
            htot = lv[0] + lv[1] + lv[2] + lv[3] + 4;
            vtot = lv[4] + lv[5] + lv[6] + lv[7] + 4;
            ce = (m_div == 2 * lv[8] + 1);
            m_div = ce ? 0 : m_div + 1;
            if (ce) begin
               if (m_h == htot - 1) begin
                  m_h = 0;
                  if (m_v == vtot - 1) begin
                     m_v = 0;
                     lv = st;
                     if (st_run == 0) m_run = 0;
                  end else m_v++;
               end else m_h++;
            end
         end
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: begin st_run = int'(cfg_wdata[0]); st[8] = int'(cfg_wdata[17:8]); end
               3'd1: begin
                  st[5] = int'(cfg_wdata[31:24]); st[6] = int'(cfg_wdata[23:14]);
                  st[7] = int'(cfg_wdata[13:6]);  st[4] = int'(cfg_wdata[5:0]);
               end
               3'd2: begin
                  st[1] = int'(cfg_wdata[25:19]); st[2] = int'(cfg_wdata[18:8]);
                  st[3] = int'(cfg_wdata[7:0]);
               end
               3'd3: st[0] = int'(cfg_wdata[7:0]);
               3'd4: st[9] = int'(cfg_wdata[2:0]);
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int hs0, ha0, vs0, va0, p;
         bit hsa, hac, vsa, vac;
         hs0 = lv[0] + 1; ha0 = hs0 + lv[1] + 1;
         vs0 = lv[4] + 1; va0 = vs0 + lv[5] + 1;
         hsa = (m_run != 0) && (m_h < hs0);
         hac = (m_run != 0) && (m_h >= ha0) && (m_h < ha0 + lv[2] + 1);
         vsa = (m_run != 0) && (m_v < vs0);
         vac = (m_run != 0) && (m_v >= va0) && (m_v < va0 + lv[6] + 1);
         p = lv[9];
         chk("R3 pix_ce", int'(pix_ce), int'((m_run != 0) && (m_div == 2 * lv[8] + 1)));
         chk("R4 R10 hsync", int'(hsync_o), hsa ? (p & 1) : 1 - (p & 1));
         chk("R5 R10 vsync", int'(vsync_o), vsa ? ((p >> 1) & 1) : 1 - ((p >> 1) & 1));
         chk("R6 R10 de", int'(de_o), (hac && vac) ? 1 - ((p >> 2) & 1) : ((p >> 2) & 1));
         chk("R11 pix_x", int'(pix_x), hac ? m_h - ha0 : 0);
         chk("R11 pix_y", int'(pix_y), vac ? m_v - va0 : 0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_ce();
      do @(negedge clk); while (!pix_ce);
   endtask

   task automatic gap(input string tag, input int exp);
      int n;
      wait_ce();
      n = 0;
      do begin @(negedge clk); n++; end while (!pix_ce);
      chk(tag, n, exp);
   endtask

   task automatic count_de(input int n_ce, output int n_de);
      n_de = 0;
      for (int i = 0; i < n_ce; i++) begin
         wait_ce();
         if (de_o) n_de++;
      end
   endtask

   // geometry: h 2/3/8/2 (total 15), v 1/2/4/1 (total 8) -> 120 strobes/frame
   localparam logic [31:0] VWORD = (32'd1 << 24) | (32'd3 << 14) | (32'd0 << 6) | 32'd0;
   localparam logic [31:0] HWORD = (32'd2 << 19) | (32'd7 << 8) | 32'd1;

   initial begin
      int n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 reset pix_ce", int'(pix_ce), 0);
      chk("R12 reset hsync", int'(hsync_o), 1);
      chk("R12 reset vsync", int'(vsync_o), 1);
      chk("R12 reset de", int'(de_o), 0);

      wr(1, VWORD); // R1
      wr(2, HWORD); // R2
      wr(3, 32'd1);
      wr(0, 32'h1);
      @(negedge clk);
      chk("R7 start vsync", int'(vsync_o), 0);
      chk("R7 start hsync", int'(hsync_o), 0);
      chk("R7 start pix_x", int'(pix_x), 0);

      gap("R3 gap div0", 2);
      for (int i = 0; i < 30; i++) wait_ce();
      count_de(120, n);
      chk("R1 R2 de per frame", n, 32);

      // R9: mid-frame divider change keeps the old rate until the boundary
      for (int i = 0; i < 20; i++) wait_ce();
      wr(0, (32'd2 << 8) | 32'h1);
      gap("R9 old divider kept", 2);
      repeat (400) @(negedge clk);
      gap("R3 gap div2", 6);

      // R10: invert both syncs from the next frame
      wr(4, 32'd3);
      repeat (1600) @(negedge clk);

      // R8: clear run mid-frame, the frame still completes
      for (int i = 0; i < 10; i++) wait_ce();
      wr(0, 32'd2 << 8);
      n = 0;
      repeat (20) begin @(negedge clk); if (pix_ce) n++; end
      chk("R8 frame continues", int'(n > 0), 1);
      repeat (800) @(negedge clk);
      n = 0;
      repeat (100) begin @(negedge clk); if (pix_ce) n++; end
      chk("R8 stopped no pix_ce", n, 0);
      chk("R8 R10 idle hsync", int'(hsync_o), 0);
      chk("R8 R10 idle vsync", int'(vsync_o), 0);
      chk("R8 idle de", int'(de_o), 0);

      // R9: idle writes apply on the next cycle
      wr(4, 32'd4);
      @(negedge clk);
      chk("R9 R10 idle de inverted", int'(de_o), 1);
      chk("R9 idle hsync", int'(hsync_o), 1);

      wr(0, 32'h1);
      @(negedge clk);
      chk("R7 restart vsync", int'(vsync_o), 0);
      repeat (600) @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_500_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule